// File: doc/BRIEF.md
# Compare-Match Waveform Output Unit

This block turns timer events into output-compare waveform bits, one per channel. Each cycle it looks at the counter's compare-match strobe, its TOP and BOTTOM strobes, the count direction and a flag that says the channel's compare value equals TOP. It then decides whether the waveform bit holds, toggles, clears or sets. A 3-bit waveform-mode code shared by all channels chooses how each channel's 2-bit output-mode field is read: plain compare behaviour, fast PWM or phase-correct PWM.

Every channel also drives an override-enable. This signal tells the pin multiplexer to use the waveform bit in place of normal port data. The pin driver itself, with its direction bit, and the counter lie outside this block. The channels share one implementation. A parameter mask picks which channels may use the 01 field code as a toggle in PWM modes; the default mask gives that right to channel 0 only.

Top module: `cmpw_top`

## Requirements
- R1: After reset every waveform bit is 0.
- R2: Channel n reads its field from out_mode[2n+1:2n]. Its override-enable is 1 exactly when that field is nonzero, whatever the waveform mode.
- R3: Waveform modes whose low two bits are 00 or 10 are the non-PWM modes. In these modes a match gives: 01 toggle, 10 clear, 11 set. Without a match the bit holds.
- R4: Field 00 holds the waveform bit in every mode.
- R5: Fast PWM is the low bits 11. Field 10 gives 1 at BOTTOM and 0 on a match. Field 11 gives 0 at BOTTOM and 1 on a match. With no event the bit holds.
- R6: In fast PWM, when a match and BOTTOM arrive in the same cycle, the BOTTOM action wins.
- R7: Phase-correct PWM is the low bits 01. On a match, field 10 gives 0 while counting up (count_down=0) and 1 while counting down. Field 11 gives the opposite value.
- R8: On a channel enabled in the toggle mask (channel 0 by default), field 01 in a PWM mode toggles on a match when waveform-mode bit 2 is 1. When that bit is 0 the channel holds.
- R9: On a channel not enabled in the toggle mask (channel 1 by default), field 01 in a PWM mode always holds.
- R10: In a PWM mode, when cmp_is_top is set and field bit 1 is 1, the match is ignored. Fast PWM still applies its BOTTOM action. Phase-correct applies its count-down action at TOP: 1 for field 10, 0 for field 11.
- R11: The waveform bit changes on the clock edge that samples the event, and is visible in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_mode | input | 3 | Waveform-mode code shared by all channels |
| out_mode | input | 2*NCH | Output-mode field per channel |
| match | input | NCH | Compare-match strobe per channel |
| at_top | input | 1 | Counter is at TOP this cycle |
| at_bottom | input | 1 | Counter is at BOTTOM this cycle |
| count_down | input | 1 | Counter is counting down |
| cmp_is_top | input | NCH | Channel's compare value equals TOP |
| wave_out | output | NCH | Waveform bit per channel |
| ovr_en | output | NCH | Pin override-enable per channel |

## Verification
The bench builds the block with two channels and the default toggle mask. Both the channel that may toggle in PWM and the channel that may not are therefore driven by one stimulus stream. It sweeps all eight waveform-mode codes, all four field codes, both starting waveform values and all 32 combinations of match, TOP, BOTTOM, direction and compare-equals-TOP. Same-cycle collisions and the TOP corner are covered in every mode.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;

    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_FAST  = 2'd1,
        KIND_PHASE = 2'd2
    } wave_kind_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } act_e;

    typedef struct packed {
        logic wave;
    } ch_state_t;

endpackage

// File: rtl/cmpw_mode_decode.sv
module cmpw_mode_decode
    import cmpw_pkg::*;
(
    input  logic [2:0]  wave_mode,
    output wave_kind_e  kind,
    output logic        alt_bit
);
    always_comb begin
        case (wave_mode[1:0])
            2'b01:   kind = KIND_PHASE;
            2'b11:   kind = KIND_FAST;
            default: kind = KIND_PLAIN;
        endcase
        alt_bit = wave_mode[2];
    end
endmodule

// File: rtl/cmpw_action.sv
module cmpw_action
    import cmpw_pkg::*;
#(
    parameter bit TOGGLE_OK = 1'b1
) (
    input  wave_kind_e  kind,
    input  logic        alt_bit,
    input  logic [1:0]  field,
    input  logic        match,
    input  logic        at_top,
    input  logic        at_bottom,
    input  logic        count_down,
    input  logic        cmp_is_top,
    output act_e        act
);
    always_comb begin
        act = ACT_HOLD;
        if (field != 2'b00) begin
            if (kind == KIND_PLAIN) begin
                if (match) begin
                    case (field)
                        2'b01:   act = ACT_TOGGLE;
                        2'b10:   act = ACT_CLEAR;
                        default: act = ACT_SET;
                    endcase
                end
            end else if (field == 2'b01) begin
                if (TOGGLE_OK && alt_bit && match)
                    act = ACT_TOGGLE;
            end else if (kind == KIND_FAST) begin
                if (at_bottom)
                    act = field[0] ? ACT_CLEAR : ACT_SET;
                else if (match && !cmp_is_top)
                    act = field[0] ? ACT_SET : ACT_CLEAR;
            end else begin
                if (cmp_is_top) begin
                    if (at_top)
                        act = field[0] ? ACT_CLEAR : ACT_SET;
                end else if (match) begin
                    act = (field[0] ^ count_down) ? ACT_SET : ACT_CLEAR;
                end
            end
        end
    end
endmodule

// File: rtl/cmpw_channel.sv
module cmpw_channel
    import cmpw_pkg::*;
#(
    parameter bit TOGGLE_OK = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  wave_kind_e  kind,
    input  logic        alt_bit,
    input  logic [1:0]  field,
    input  logic        match,
    input  logic        at_top,
    input  logic        at_bottom,
    input  logic        count_down,
    input  logic        cmp_is_top,
    output logic        wave,
    output logic        ovr
);
    act_e      act;
    ch_state_t st_d, st_q;

    cmpw_action #(.TOGGLE_OK(TOGGLE_OK)) u_act (
        .kind       (kind),
        .alt_bit    (alt_bit),
        .field      (field),
        .match      (match),
        .at_top     (at_top),
        .at_bottom  (at_bottom),
        .count_down (count_down),
        .cmp_is_top (cmp_is_top),
        .act        (act)
    );

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_TOGGLE: st_d.wave = ~st_q.wave;
            ACT_CLEAR:  st_d.wave = 1'b0;
            ACT_SET:    st_d.wave = 1'b1;
            default:    st_d.wave = st_q.wave;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave = st_q.wave;
    assign ovr  = (field != 2'b00);

    // R4
    disconnected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field == 2'b00) |=> (wave == $past(wave)));

    // R6
    fast_bottom_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_FAST && field[1] && at_bottom) |=> (wave == ~$past(field[0])));

    // R3
    plain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_PLAIN && field == 2'b10 && match) |=> (wave == 1'b0));

    // R10
    phase_top_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_PHASE && field[1] && cmp_is_top && at_top) |=> (wave == ~$past(field[0])));

    // R9
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!TOGGLE_OK && kind != KIND_PLAIN && field == 2'b01) |=> $stable(wave));
endmodule

// File: rtl/cmpw_top.sv
module cmpw_top
    import cmpw_pkg::*;
#(
    parameter int               NCH             = 2,
    parameter logic [NCH-1:0]   PWM_TOGGLE_MASK = 2'b01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          wave_mode,
    input  logic [2*NCH-1:0]    out_mode,
    input  logic [NCH-1:0]      match,
    input  logic                at_top,
    input  logic                at_bottom,
    input  logic                count_down,
    input  logic [NCH-1:0]      cmp_is_top,
    output logic [NCH-1:0]      wave_out,
    output logic [NCH-1:0]      ovr_en
);
    localparam int FW = 2;

    wave_kind_e kind;
    logic       alt_bit;

    cmpw_mode_decode u_dec (
        .wave_mode (wave_mode),
        .kind      (kind),
        .alt_bit   (alt_bit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cmpw_channel #(.TOGGLE_OK(PWM_TOGGLE_MASK[c])) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .kind       (kind),
            .alt_bit    (alt_bit),
            .field      (out_mode[FW*c +: FW]),
            .match      (match[c]),
            .at_top     (at_top),
            .at_bottom  (at_bottom),
            .count_down (count_down),
            .cmp_is_top (cmp_is_top[c]),
            .wave       (wave_out[c]),
            .ovr        (ovr_en[c])
        );
    end
endmodule

// File: tb/cmpw_top_test.sv
module cmpw_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     wave_mode = '0;
    logic [3:0]     out_mode = '0;
    logic [1:0]     match = '0;
    logic           at_top = 1'b0;
    logic           at_bottom = 1'b0;
    logic           count_down = 1'b0;
    logic [1:0]     cmp_is_top = '0;
    logic [1:0]     wave_out;
    logic [1:0]     ovr_en;

    int total = 0;
    int bad = 0;

    cmpw_top #(.NCH(NCH), .PWM_TOGGLE_MASK(2'b01)) uut (
        .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .out_mode(out_mode),
        .match(match), .at_top(at_top), .at_bottom(at_bottom),
        .count_down(count_down), .cmp_is_top(cmp_is_top),
        .wave_out(wave_out), .ovr_en(ovr_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Expected next waveform value from the requirements
    function automatic logic model(input int ch, input logic [2:0] wm, input logic [1:0] f,
                                   input logic m, input logic bot, input logic top,
                                   input logic dn, input logic ct, input logic cur,
                                   output string tag);
        logic [1:0] lo;
        lo = wm[1:0];
        if (f == 2'b00) begin tag = "R4"; return cur; end
        if (lo == 2'b00 || lo == 2'b10) begin
            tag = "R3";
            if (!m) return cur;
            if (f == 2'b01) return ~cur;
            return f[0];
        end
        if (f == 2'b01) begin
            if (ch == 0) begin tag = "R8"; return (wm[2] && m) ? ~cur : cur; end
            tag = "R9"; return cur;
        end
        if (lo == 2'b11) begin
            if (bot) begin tag = m ? "R6" : "R5"; return ~f[0]; end
            if (m && ct) begin tag = "R10"; return cur; end
            tag = "R5";
            return m ? f[0] : cur;
        end
        if (ct) begin tag = "R10"; return top ? ~f[0] : cur; end
        tag = "R7";
        return m ? (f[0] ^ dn) : cur;
    endfunction

    initial begin
        string tg;
        logic  ex;
        #(CLK_PERIOD * 3 + 2);
        chk(wave_out[0], 1'b0, "R1 ch0 in reset");
        chk(wave_out[1], 1'b0, "R1 ch1 in reset");
        rst_n = 1'b1;
        step();
        chk(wave_out[0], 1'b0, "R1 ch0 after reset");
        chk(wave_out[1], 1'b0, "R1 ch1 after reset");

        for (int wm = 0; wm < 8; wm++) begin
            for (int f = 0; f < 4; f++) begin
                for (int init = 0; init < 2; init++) begin
                    for (int v = 0; v < 32; v++) begin
                        // precondition through plain set/clear (R3)
                        wave_mode  = 3'b000;
                        out_mode   = init[0] ? 4'b1111 : 4'b1010;
                        match      = 2'b11;
                        at_top     = 1'b0;
                        at_bottom  = 1'b0;
                        count_down = 1'b0;
                        cmp_is_top = 2'b00;
                        step();
                        chk(wave_out[0], init[0], "R3 precondition ch0");
                        chk(wave_out[1], init[0], "R3 precondition ch1");
                        // vector under test
                        wave_mode  = wm[2:0];
                        out_mode   = {f[1:0], f[1:0]};
                        match      = {2{v[0]}};
                        at_bottom  = v[1];
                        at_top     = v[2];
                        count_down = v[3];
                        cmp_is_top = {2{v[4]}};
                        #1;
                        chk(ovr_en[0], f != 0, "R2 ch0 override");
                        chk(ovr_en[1], f != 0, "R2 ch1 override");
                        step();
                        // R11: new value visible one edge after the event
                        for (int c = 0; c < NCH; c++) begin
                            ex = model(c, wm[2:0], f[1:0], v[0], v[1], v[2], v[3], v[4],
                                       init[0], tg);
                            chk(wave_out[c], ex, $sformatf("%s R11 ch%0d wm=%0d f=%0d v=%0d init=%0d",
                                                          tg, c, wm, f, v, init));
                        end
                    end
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule